// File: doc/BRIEF.md
# Five-Voice Wavetable Tone Engine

This block is the per-clock tone engine behind a five-voice wavetable sound generator. Every voice owns a 12-bit down-counter that is loaded from its pitch word. Whenever the counter runs out, the voice's 5-bit wave position moves one step forward. The surrounding register file and waveform memory read the positions on the `wave_pos` output and return the addressed signed 8-bit sample of each voice on `samp_bus`. The engine scales each sample by the voice's 4-bit volume, silences voices that are switched off, and registers the sum of the five voice outputs as an 11-bit signed mixed sample.

Two mode inputs change how the counter behaves. With `cnt_split` set, the counter is treated as two independent halves, bits 7:0 and bits 11:8, and each half counts down and wraps on its own. With `cnt_lowbyte` set, only the low byte is tested for expiry. The register file has two more controls. A per-voice load pulse reloads the counter with the pitch, as on a pitch write. A per-voice clear pulse returns the position to zero. All counting, stepping and mix updates happen only in cycles where `tick_en` is high.

Top module: `wtone_engine`

## Requirements
- R1: A voice whose pitch is below 9 is halted. Its counter and its position keep their values while `tick_en` is high, and it still contributes its scaled sample to the mix.
- R2: In the default mode (`cnt_split`=0, `cnt_lowbyte`=0), each enabled tick decrements the whole 12-bit counter by one. A step happens on the tick whose pre-decrement value is zero. After a load, a voice with pitch P therefore steps once every P+1 ticks.
- R3: With `cnt_split`=1 and `cnt_lowbyte`=0, bits 7:0 and bits 11:8 each decrement by one per tick, each wrapping independently. A step happens when bits 11:8 were zero before the tick, so the period is bits 11:8 of the pitch plus one.
- R4: With `cnt_lowbyte`=1, a step happens when bits 7:0 were zero before the tick. This test takes priority over the split test when both modes are set, and the period is bits 7:0 of the pitch plus one.
- R5: On a step, the position (`wave_pos` bits 5v+4:5v for voice v) increments modulo 32 and the counter reloads from the pitch.
- R6: A high `load_cnt[v]` sets the voice's counter to its pitch at the next clock. This happens regardless of `tick_en` or halt, overrides that cycle's count, and suppresses that cycle's step.
- R7: A high `clr_pos[v]` sets the voice's position to zero at the next clock and overrides a step in the same cycle.
- R8: Each voice outputs floor(sample × volume / 16) when `voice_on[v]` is 1, which is an arithmetic right shift by 4 (for example, −1 × 1 gives −1). It outputs 0 when `voice_on[v]` is 0. The sample is taken as two's complement.
- R9: On every clock with `tick_en` high, `mix_out` registers the sum of the five voice outputs as an 11-bit two's-complement value. The range is −600 to 595.
- R10: While `rst_n` is low, every counter, every position and `mix_out` are zero. Reset asserts asynchronously and releases on a clock edge.
- R11: While `tick_en` is low and no load or clear pulse is present, counters, positions and `mix_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_en | input | 1 | Clock enable for counting and mixing |
| cnt_split | input | 1 | Split the counter into 8-bit and 4-bit halves |
| cnt_lowbyte | input | 1 | Step on expiry of the low byte |
| pitch_bus | input | 60 | Pitch of voice v in bits 12v+11:12v |
| vol_bus | input | 20 | Volume of voice v in bits 4v+3:4v |
| voice_on | input | 5 | Per-voice output enable |
| load_cnt | input | 5 | Per-voice counter reload pulse |
| clr_pos | input | 5 | Per-voice position clear pulse |
| samp_bus | input | 40 | Signed sample at voice v's position, bits 8v+7:8v |
| wave_pos | output | 25 | Position of voice v in bits 5v+4:5v |
| mix_out | output | 11 | Registered signed mix of all voices |

## Verification
The bench measures periods at their exact boundaries: a tick before the step and the tick of the step. A design that used a period of P instead of P+1, or tested the post-decrement value, shows up here one tick early. The position is stepped through its modulo-32 wrap. The split and low-byte modes each use a pitch whose full 12-bit period differs greatly from the mode's period. A design that inverted the mode priority would step at twice the rate. A reload is issued mid-count and a clear is placed on the very tick that would step, so a design that let either lose to the count leaves the wrong position. The output cases cover −1 × 1, where a shift that rounds toward zero gives 0. They also cover the full positive and negative extremes of five voices, which catch too narrow a sum, and disabled voices carrying a full-scale sample.

// File: rtl/wtone_pkg.sv
package wtone_pkg;
  localparam int NUM_VOICES = 5;
  localparam int PITCH_W    = 12;
  localparam int LOW_W      = 8;
  localparam int HI_W       = PITCH_W - LOW_W;
  localparam int POS_W      = 5;
  localparam int SAMP_W     = 8;
  localparam int VOL_W      = 4;
  localparam int HALT_MIN   = 9;
  localparam int PROD_W     = SAMP_W + VOL_W + 1;
  localparam int VOUT_W     = SAMP_W + 1;
  localparam int MIX_W      = 11;
endpackage

// File: rtl/wtone_voice.sv
module wtone_voice
  import wtone_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               split_i,
  input  logic               lowbyte_i,
  input  logic               load_i,
  input  logic               clr_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic [POS_W-1:0]   pos_o
);
  logic [PITCH_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic               halted, step;

  always_comb begin
    halted = (pitch_i < PITCH_W'(HALT_MIN));
    if (split_i)
      cnt_dec = {cnt_q[PITCH_W-1:LOW_W] - HI_W'(1), cnt_q[LOW_W-1:0] - LOW_W'(1)};
    else
      cnt_dec = cnt_q - PITCH_W'(1);
    if (lowbyte_i)
      step = (cnt_q[LOW_W-1:0] == '0);
    else if (split_i)
      step = (cnt_q[PITCH_W-1:LOW_W] == '0);
    else
      step = (cnt_q == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    if (load_i) begin
      cnt_d = pitch_i;
    end else if (tick_en && !halted) begin
      if (step) begin
        cnt_d = pitch_i;
        pos_d = pos_q + POS_W'(1);
      end else begin
        cnt_d = cnt_dec;
      end
    end
    if (clr_i) pos_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  assign pos_o = pos_q;

  // R1: halted voice keeps its position
  a_r1_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clr_i) |=> (pos_q == $past(pos_q)));
  // R6: load pulse places pitch in counter
  a_r6_load_pitch: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(pitch_i)));
  // R7: clear pulse zeroes position
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pos_q == '0));
  // R5: position moves by at most one step
  a_r5_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1))));
  // R11: idle clock leaves counter and position alone
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_i && !clr_i) |=> ($stable(cnt_q) && $stable(pos_q)));
endmodule

// File: rtl/wtone_scale.sv
module wtone_scale
  import wtone_pkg::*;
(
  input  logic                     on_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic        [VOL_W-1:0]  vol_i,
  output logic signed [VOUT_W-1:0] out_o
);
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(samp_i) * $signed({1'b0, vol_i});
    if (on_i) out_o = VOUT_W'(prod >>> VOL_W);
    else      out_o = '0;
  end
endmodule

// File: rtl/wtone_mixer.sv
module wtone_mixer
  import wtone_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic [NUM_VOICES-1:0]    on_i,
  input  logic signed [VOUT_W-1:0] vout_i [NUM_VOICES],
  output logic signed [MIX_W-1:0]  mix_o
);
  logic signed [MIX_W-1:0] acc, mix_q, mix_d;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_VOICES; i++)
      acc = acc + MIX_W'(vout_i[i]);
    mix_d = tick_en ? acc : mix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mix_q <= '0;
    else        mix_q <= mix_d;
  end

  assign mix_o = mix_q;

  // R11: mix holds without a tick
  a_r11_mix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(mix_q));

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_off
    // R8: switched-off voice reaches the adder as zero
    a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !on_i[g] |-> (vout_i[g] == '0));
  end
endmodule

// File: rtl/wtone_engine.sv
module wtone_engine
  import wtone_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick_en,
  input  logic                             cnt_split,
  input  logic                             cnt_lowbyte,
  input  logic [NUM_VOICES*PITCH_W-1:0]    pitch_bus,
  input  logic [NUM_VOICES*VOL_W-1:0]      vol_bus,
  input  logic [NUM_VOICES-1:0]            voice_on,
  input  logic [NUM_VOICES-1:0]            load_cnt,
  input  logic [NUM_VOICES-1:0]            clr_pos,
  input  logic [NUM_VOICES*SAMP_W-1:0]     samp_bus,
  output logic [NUM_VOICES*POS_W-1:0]      wave_pos,
  output logic signed [MIX_W-1:0]          mix_out
);
  logic [1:0]               rst_sync;
  logic                     rst_n_s;
  logic signed [VOUT_W-1:0] vout [NUM_VOICES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    wtone_voice u_voice (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .tick_en   (tick_en),
      .split_i   (cnt_split),
      .lowbyte_i (cnt_lowbyte),
      .load_i    (load_cnt[v]),
      .clr_i     (clr_pos[v]),
      .pitch_i   (pitch_bus[v*PITCH_W +: PITCH_W]),
      .pos_o     (wave_pos[v*POS_W +: POS_W])
    );
    wtone_scale u_scale (
      .on_i   (voice_on[v]),
      .samp_i (samp_bus[v*SAMP_W +: SAMP_W]),
      .vol_i  (vol_bus[v*VOL_W +: VOL_W]),
      .out_o  (vout[v])
    );
  end

  wtone_mixer u_mix (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_en (tick_en),
    .on_i    (voice_on),
    .vout_i  (vout),
    .mix_o   (mix_out)
  );

  // R10: reset leaves positions and mix at zero
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n_s |-> (wave_pos == '0 && mix_out == '0));
endmodule

// File: tb/sim_wtone_engine.sv
`timescale 1ns/1ps
module sim_wtone_engine;
  logic clk = 0, rst_n = 0, tick_en = 0, cnt_split = 0, cnt_lowbyte = 0;
  logic [59:0] pitch_bus;
  logic [19:0] vol_bus;
  logic [39:0] samp_bus;
  logic [4:0]  voice_on = 0, load_cnt = 0, clr_pos = 0;
  logic [24:0] wave_pos;
  logic signed [10:0] mix_out;
  logic [11:0] pitch [5];
  logic [3:0]  vol [5];
  logic [7:0]  samp [5];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 5; i++) begin
      pitch_bus[i*12 +: 12] = pitch[i];
      vol_bus[i*4 +: 4]     = vol[i];
      samp_bus[i*8 +: 8]    = samp[i];
    end

  wtone_engine u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_split(cnt_split),
    .cnt_lowbyte(cnt_lowbyte), .pitch_bus(pitch_bus), .vol_bus(vol_bus), .voice_on(voice_on),
    .load_cnt(load_cnt), .clr_pos(clr_pos), .samp_bus(samp_bus), .wave_pos(wave_pos),
    .mix_out(mix_out));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pos(int v);
    return int'(wave_pos[v*5 +: 5]);
  endfunction

  task automatic run(int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic prime(int v, logic [11:0] p);
    pitch[v] = p; load_cnt[v] = 1; clr_pos[v] = 1;
    @(negedge clk);
    load_cnt[v] = 0; clr_pos[v] = 0;
  endtask

  task automatic t_reset_state;
    for (int v = 0; v < 5; v++) check("R10 reset position", pos(v), 0);
    check("R10 reset mix", mix_out, 0);
  endtask

  task automatic t_halt;
    prime(3, 12'd8);
    run(200);
    check("R1 pitch 8 halted", pos(3), 0);
    prime(3, 12'd9);
    run(10);
    check("R1 pitch 9 runs", pos(3), 1);
    pitch[3] = 0;
  endtask

  task automatic t_normal;
    prime(2, 12'd9);
    run(9);  check("R2 one tick early", pos(2), 0);
    run(1);  check("R2 step at P+1", pos(2), 1);
    run(310); check("R5 wrap at 32", pos(2), 0);
    run(10); check("R5 after wrap", pos(2), 1);
    prime(2, 12'd20);
    run(21); check("R2 pitch 20 first", pos(2), 1);
    run(21); check("R5 reload keeps period", pos(2), 2);
    pitch[2] = 0;
  endtask

  task automatic t_modes;
    cnt_lowbyte = 1;
    prime(0, 12'h30A);
    run(10); check("R4 low byte early", pos(0), 0);
    run(1);  check("R4 low byte step", pos(0), 1);
    run(11); check("R4 low byte second", pos(0), 2);
    cnt_lowbyte = 0; cnt_split = 1;
    prime(0, 12'h20F);
    run(2); check("R3 split early", pos(0), 0);
    run(1); check("R3 split step", pos(0), 1);
    run(6); check("R3 split third", pos(0), 3);
    cnt_lowbyte = 1;
    prime(0, 12'h205);
    run(5); check("R4 priority early", pos(0), 0);
    run(1); check("R4 priority step", pos(0), 1);
    run(6); check("R4 priority second", pos(0), 2);
    cnt_lowbyte = 0; cnt_split = 0; pitch[0] = 0;
  endtask

  task automatic t_load_clear;
    prime(1, 12'd9);
    run(5);
    load_cnt[1] = 1; tick_en = 1;
    @(negedge clk);
    load_cnt[1] = 0; tick_en = 0;
    run(9); check("R6 reload delays step", pos(1), 0);
    run(1); check("R6 step after reload", pos(1), 1);
    prime(1, 12'd9);
    run(9);
    clr_pos[1] = 1; tick_en = 1;
    @(negedge clk);
    clr_pos[1] = 0; tick_en = 0;
    check("R7 clear beats step", pos(1), 0);
    run(10); check("R7 counting resumes", pos(1), 1);
    pitch[1] = 0;
  endtask

  task automatic t_idle;
    prime(4, 12'd9);
    repeat (30) @(negedge clk);
    check("R11 no tick no step", pos(4), 0);
    run(10); check("R11 counter held", pos(4), 1);
    pitch[4] = 0;
  endtask

  task automatic set_all(logic [4:0] on, logic [7:0] s, logic [3:0] vl);
    voice_on = on;
    for (int v = 0; v < 5; v++) begin samp[v] = s; vol[v] = vl; end
  endtask

  task automatic t_output;
    set_all(5'b00001, 8'h80, 4'd15); run(1); check("R8 -128x15", mix_out, -120);
    set_all(5'b00001, 8'hFF, 4'd1);  run(1); check("R8 floor -1x1", mix_out, -1);
    set_all(5'b11111, 8'h7F, 4'd15); run(1); check("R9 max sum", mix_out, 595);
    set_all(5'b11111, 8'h80, 4'd15); run(1); check("R9 min sum", mix_out, -600);
    set_all(5'b00000, 8'h7F, 4'd15); run(1); check("R8 disabled silent", mix_out, 0);
    set_all(5'b00011, 8'h00, 4'd0);
    samp[0] = 8'd100; vol[0] = 4'd8; samp[1] = 8'hCE; vol[1] = 4'd3;
    samp[2] = 8'h7F;  vol[2] = 4'd15;
    run(1); check("R9 mixed voices", mix_out, 40);
    voice_on = 5'b11111;
    repeat (3) @(negedge clk);
    check("R11 mix held", mix_out, 40);
    run(1); check("R1 halted voices still sound", mix_out, 40 + 119 + 0);
  endtask

  task automatic t_reset_mid;
    prime(2, 12'd9);
    run(25);
    rst_n = 0; #3;
    check("R10 async position", pos(2), 0);
    check("R10 async mix", mix_out, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int v = 0; v < 5; v++) begin pitch[v] = 0; vol[v] = 0; samp[v] = 0; end
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_halt();
    t_normal();
    t_modes();
    t_load_clear();
    t_idle();
    t_output();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule